// File: doc/BRIEF.md
# OTP Code-Memory Protection Controller

This block guards the one-time-programmable program memory of a small 8-bit controller. It holds a two-bit lock field and decodes it into one of four protection levels. The lock field is loaded from a nonvolatile input while reset is asserted. The level that results decides four things: which programming-mode operations are honoured, whether verification reads return real code bytes, whether table-lookup fetches made from external code may see internal memory, and whether the external-access pin may select external execution.

The surrounding logic sends requests: a programming operation with its qualifier, a table-lookup fetch marked as coming from external code, the live external-access pin, and a flag saying that an internal jump has crossed the internal memory boundary. The block answers each one with a registered grant or refusal and the data to return. A refused read gives a fixed blank byte and raises a one-cycle violation pulse. Lock programming can only clear bits, so the protection level can only rise while the chip runs.

Top module: `otp_guard`

## Requirements
- R1: While reset is low, the lock field loads from `lockInit`. The `level` output then shows lock 11 as level 0, 10 as level 1, 01 as level 2 and 00 as level 3.
- R2: At level 0 the external-access pin is used live. One cycle after `extPin` is low (1 = internal, 0 = external), `extExec` is 1.
- R3: At level 1 and above, the `extPin` value captured during reset is used. Later changes of `extPin` leave `extExec` unchanged.
- R4: A table-lookup request with `tblFromExt`=1 at level 1 or above returns `tblData`=0xFF one cycle later and pulses `violation` for exactly one cycle. At level 0, and for any internal table lookup, `tblData` is `memData`.
- R5: A program-byte operation (`progOp`=0) is granted at level 0, with `progGrant` and `cellWrEn` high one cycle later. At level 1 and above it is denied, with `progDeny` high and `cellWrEn` low.
- R6: A read-byte operation (`progOp`=1) returns `memData` at level 0 in any mode, and at level 1 only when `modeTwo`=1. In every other case it returns 0xFF on `rdData`, pulses `violation` and is denied.
- R7: At level 3, `extExec` is 1 only when `jumpAbove` was 1 in the previous cycle. A low external-access pin does not select external execution.
- R8: Read-lock (`progOp`=3) is granted at every level and returns `rdData` = {6'b0, lock}. Read-version (`progOp`=4) is granted at every level and returns parameter VERSION_BYTE.
- R9: Program-lock (`progOp`=2) is always granted. The new lock is the AND of the old lock and `progData[1:0]`, so no bit returns to 1. `level` shows the new level two cycles after the request.
- R10: An operation code from 5 to 7 is denied and leaves `rdData` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset. Lock field and pin are captured while low |
| lockInit | input | 2 | Nonvolatile lock bits, bit 1 first |
| extPin | input | 1 | External-access pin, 0 requests external execution |
| jumpAbove | input | 1 | Internal jump has gone above the internal memory boundary |
| progReq | input | 1 | Programming-mode operation request |
| progOp | input | 3 | Operation: 0 program byte, 1 read byte, 2 program lock, 3 read lock, 4 read version |
| modeTwo | input | 1 | Read byte uses the second verification mode |
| progData | input | 8 | Write data. Bits 1:0 are the lock mask for program-lock |
| tblReq | input | 1 | Table-lookup fetch request |
| tblFromExt | input | 1 | Table lookup issued from external program memory |
| memData | input | 8 | Byte read from the code array |
| level | output | 2 | Current protection level |
| progGrant | output | 1 | Operation accepted (one-cycle pulse) |
| progDeny | output | 1 | Operation refused (one-cycle pulse) |
| cellWrEn | output | 1 | Write strobe to the code array |
| rdData | output | 8 | Programming-mode read result, held between reads |
| tblData | output | 8 | Table-lookup result, held between lookups |
| violation | output | 1 | One-cycle pulse on a refused read or table lookup |
| extExec | output | 1 | External code execution selected |

## Verification
Every grant, refusal, data byte, violation pulse and `extExec` value is due one clock edge after the inputs that cause it. A change to the lock field shows on `level` two edges after the program-lock request, because it passes through the lock register and then the level register. The bench changes inputs on the falling edge and reads results on the next falling edge. For the level it waits one more falling edge, so every sample falls in the cycle in which the value is due. Each violation pulse is also checked one cycle later to confirm that it has cleared.

// File: rtl/otp_guard_pkg.sv
package otp_guard_pkg;

  localparam int LOCK_W = 2;

  typedef enum logic [1:0] {
    LVL0 = 2'd0,
    LVL1 = 2'd1,
    LVL2 = 2'd2,
    LVL3 = 2'd3
  } level_e;

  typedef enum logic [2:0] {
    OP_PROG_BYTE = 3'd0,
    OP_READ_BYTE = 3'd1,
    OP_PROG_LOCK = 3'd2,
    OP_READ_LOCK = 3'd3,
    OP_READ_VER  = 3'd4
  } prog_op_e;

  // control -> datapath strobes
  typedef struct packed {
    logic ldMem;
    logic ldLock;
    logic ldVer;
    logic ldBlank;
    logic tblPass;
    logic tblBlank;
    logic wrCell;
    logic grant;
    logic deny;
    logic viol;
    logic extExec;
  } strobe_t;

  // all-ones lock means unprotected; each cleared bit adds protection
  function automatic level_e lockToLevel(input logic [LOCK_W-1:0] lk);
    return level_e'(~lk);
  endfunction

endpackage

// File: rtl/otp_guard_ctrl.sv
module otp_guard_ctrl
  import otp_guard_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [LOCK_W-1:0] lockInit,
  input  logic              extPin,
  input  logic              jumpAbove,
  input  logic              progReq,
  input  logic [2:0]        progOp,
  input  logic              modeTwo,
  input  logic [LOCK_W-1:0] lockMask,
  input  logic              tblReq,
  input  logic              tblFromExt,
  output level_e            levelQ,
  output logic [LOCK_W-1:0] lockQ,
  output strobe_t           strobe
);

  logic   pinLatchQ;
  logic   pinEff;
  logic   lockWr;
  logic   readOk;
  logic   tblRefused;
  logic   readRefused;
  level_e levelNext;

  assign levelNext = lockToLevel(lockQ);

  // lock field, decoded level and pin capture: all loaded during reset
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lockQ     <= lockInit;
      levelQ    <= lockToLevel(lockInit);
      pinLatchQ <= extPin;
    end else begin
      if (lockWr) begin
        lockQ <= lockQ & lockMask;
      end
      levelQ <= levelNext;
    end
  end

  // at level 0 the pin is live; above it the reset-time capture rules
  assign pinEff = (levelQ == LVL0) ? extPin : pinLatchQ;

  // a read-byte request uses verification mode 2 only at level 1
  always_comb begin
    unique case (levelQ)
      LVL0:    readOk = 1'b1;
      LVL1:    readOk = modeTwo;
      default: readOk = 1'b0;
    endcase
  end

  assign tblRefused = tblReq && tblFromExt && (levelQ != LVL0);
  assign lockWr     = progReq && (progOp == OP_PROG_LOCK);

  always_comb begin
    strobe      = '0;
    readRefused = 1'b0;
    if (progReq) begin
      case (progOp)
        OP_PROG_BYTE: begin
          if (levelQ == LVL0) begin
            strobe.wrCell = 1'b1;
            strobe.grant  = 1'b1;
          end else begin
            strobe.deny = 1'b1;
          end
        end
        OP_READ_BYTE: begin
          if (readOk) begin
            strobe.ldMem = 1'b1;
            strobe.grant = 1'b1;
          end else begin
            strobe.ldBlank = 1'b1;
            strobe.deny    = 1'b1;
            readRefused    = 1'b1;
          end
        end
        OP_PROG_LOCK: strobe.grant = 1'b1;
        OP_READ_LOCK: begin
          strobe.ldLock = 1'b1;
          strobe.grant  = 1'b1;
        end
        OP_READ_VER: begin
          strobe.ldVer = 1'b1;
          strobe.grant = 1'b1;
        end
        default: strobe.deny = 1'b1;
      endcase
    end
    if (tblReq) begin
      strobe.tblBlank = tblRefused;
      strobe.tblPass  = !tblRefused;
    end
    strobe.viol    = tblRefused || readRefused;
    strobe.extExec = jumpAbove || (!pinEff && (levelQ != LVL3));
  end

  // protection never falls back while running
  assert_level_monotonic_R9: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (levelQ >= $past(levelQ)));

  // no lock bit returns from 0 to 1
  assert_lock_clear_only_R9: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> ((lockQ & ~$past(lockQ)) == '0));

endmodule

// File: rtl/otp_guard_dp.sv
module otp_guard_dp
  import otp_guard_pkg::*;
#(
  parameter int              DATA_W       = 8,
  parameter logic [DATA_W-1:0] VERSION_BYTE = 8'hA5,
  parameter logic [DATA_W-1:0] BLANK        = 8'hFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [DATA_W-1:0] memData,
  input  logic [LOCK_W-1:0] lockQ,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] tblData,
  output logic              progGrant,
  output logic              progDeny,
  output logic              cellWrEn,
  output logic              violation,
  output logic              extExec
);

  localparam int PAD_W = DATA_W - LOCK_W;

  logic [DATA_W-1:0] lockByte;
  assign lockByte = {{PAD_W{1'b0}}, lockQ};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData  <= BLANK;
      tblData <= BLANK;
    end else begin
      if (strobe.ldMem)        rdData <= memData;
      else if (strobe.ldLock)  rdData <= lockByte;
      else if (strobe.ldVer)   rdData <= VERSION_BYTE;
      else if (strobe.ldBlank) rdData <= BLANK;
      if (strobe.tblPass)       tblData <= memData;
      else if (strobe.tblBlank) tblData <= BLANK;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      progGrant <= 1'b0;
      progDeny  <= 1'b0;
      cellWrEn  <= 1'b0;
      violation <= 1'b0;
      extExec   <= 1'b0;
    end else begin
      progGrant <= strobe.grant;
      progDeny  <= strobe.deny;
      cellWrEn  <= strobe.wrCell;
      violation <= strobe.viol;
      extExec   <= strobe.extExec;
    end
  end

  // an operation is either accepted or refused, never both
  assert_grant_xor_deny_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({progGrant, progDeny}));

  // a cell write is always part of a grant
  assert_write_granted_R5: assert property (@(posedge clk) disable iff (!rstN)
    cellWrEn |-> progGrant);

endmodule

// File: rtl/otp_guard.sv
module otp_guard
  import otp_guard_pkg::*;
#(
  parameter int              DATA_W       = 8,
  parameter logic [DATA_W-1:0] VERSION_BYTE = 8'hA5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        lockInit,
  input  logic              extPin,
  input  logic              jumpAbove,
  input  logic              progReq,
  input  logic [2:0]        progOp,
  input  logic              modeTwo,
  input  logic [DATA_W-1:0] progData,
  input  logic              tblReq,
  input  logic              tblFromExt,
  input  logic [DATA_W-1:0] memData,
  output logic [1:0]        level,
  output logic              progGrant,
  output logic              progDeny,
  output logic              cellWrEn,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] tblData,
  output logic              violation,
  output logic              extExec
);

  localparam logic [DATA_W-1:0] BLANK = '1;

  level_e            levelQ;
  logic [LOCK_W-1:0] lockQ;
  strobe_t           strobe;

  otp_guard_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .lockInit   (lockInit),
    .extPin     (extPin),
    .jumpAbove  (jumpAbove),
    .progReq    (progReq),
    .progOp     (progOp),
    .modeTwo    (modeTwo),
    .lockMask   (progData[LOCK_W-1:0]),
    .tblReq     (tblReq),
    .tblFromExt (tblFromExt),
    .levelQ     (levelQ),
    .lockQ      (lockQ),
    .strobe     (strobe)
  );

  otp_guard_dp #(
    .DATA_W       (DATA_W),
    .VERSION_BYTE (VERSION_BYTE),
    .BLANK        (BLANK)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .memData   (memData),
    .lockQ     (lockQ),
    .rdData    (rdData),
    .tblData   (tblData),
    .progGrant (progGrant),
    .progDeny  (progDeny),
    .cellWrEn  (cellWrEn),
    .violation (violation),
    .extExec   (extExec)
  );

  assign level = levelQ;

  assert_tbl_blank_R4: assert property (@(posedge clk) disable iff (!rstN)
    (tblReq && tblFromExt && (level != 2'd0)) |=> ((tblData == BLANK) && violation));

  assert_prog_refused_R5: assert property (@(posedge clk) disable iff (!rstN)
    (progReq && (progOp == 3'd0) && (level != 2'd0)) |=> (!cellWrEn && progDeny));

  assert_ext_blocked_R7: assert property (@(posedge clk) disable iff (!rstN)
    ((level == 2'd3) && !jumpAbove) |=> !extExec);

  assert_read_refused_R6: assert property (@(posedge clk) disable iff (!rstN)
    (progReq && (progOp == 3'd1) && (level >= 2'd2)) |=> ((rdData == BLANK) && violation));

endmodule

// File: tb/tb_otp_guard.sv
module tb_otp_guard;

  localparam logic [7:0] VER = 8'hA5;

  logic       clk = 1'b0;
  logic       rstN;
  logic [1:0] lockInit;
  logic       extPin, jumpAbove, progReq, modeTwo, tblReq, tblFromExt;
  logic [2:0] progOp;
  logic [7:0] progData, memData;
  logic [1:0] level;
  logic       progGrant, progDeny, cellWrEn, violation, extExec;
  logic [7:0] rdData, tblData;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  otp_guard #(.DATA_W(8), .VERSION_BYTE(VER)) dut (
    .clk(clk), .rstN(rstN), .lockInit(lockInit), .extPin(extPin),
    .jumpAbove(jumpAbove), .progReq(progReq), .progOp(progOp),
    .modeTwo(modeTwo), .progData(progData), .tblReq(tblReq),
    .tblFromExt(tblFromExt), .memData(memData), .level(level),
    .progGrant(progGrant), .progDeny(progDeny), .cellWrEn(cellWrEn),
    .rdData(rdData), .tblData(tblData), .violation(violation),
    .extExec(extExec)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    progReq = 0; progOp = 0; modeTwo = 0; progData = 0;
    tblReq = 0; tblFromExt = 0; jumpAbove = 0;
  endtask

  task automatic doReset(input logic [1:0] lk, input logic pin);
    @(negedge clk);
    rstN = 0; lockInit = lk; extPin = pin; idle();
    repeat (2) @(negedge clk);
    rstN = 1;
  endtask

  // drive an operation for one cycle; results are due at the next falling edge
  task automatic op(input logic [2:0] code, input logic [7:0] data, input logic m2);
    progReq = 1; progOp = code; progData = data; modeTwo = m2;
    @(negedge clk);
    progReq = 0;
  endtask

  task automatic tbl(input logic fromExt);
    tblReq = 1; tblFromExt = fromExt;
    @(negedge clk);
    tblReq = 0; tblFromExt = 0;
  endtask

  task automatic t_decode_R1();
    for (int k = 0; k < 4; k++) begin
      doReset(2'(k), 1'b1);
      chk("R1 level decode", level, 3 - k);
      chk("R1 reset no grant", progGrant, 0);
    end
  endtask

  task automatic t_livePin_R2();
    doReset(2'b11, 1'b1);
    extPin = 0; @(negedge clk);
    chk("R2 live pin low", extExec, 1);
    extPin = 1; @(negedge clk);
    chk("R2 live pin high", extExec, 0);
  endtask

  task automatic t_latch_R3();
    doReset(2'b10, 1'b0);
    extPin = 1; @(negedge clk); @(negedge clk);
    chk("R3 latched low kept", extExec, 1);
    doReset(2'b01, 1'b1);
    extPin = 0; @(negedge clk); @(negedge clk);
    chk("R3 latched high kept", extExec, 0);
    extPin = 1;
  endtask

  task automatic t_table_R4();
    doReset(2'b11, 1'b1);
    memData = 8'h3C; tbl(1'b1);
    chk("R4 lvl0 ext data", tblData, 8'h3C);
    chk("R4 lvl0 no viol", violation, 0);
    doReset(2'b10, 1'b1);
    memData = 8'h5A; tbl(1'b1);
    chk("R4 lvl1 ext blank", tblData, 8'hFF);
    chk("R4 lvl1 viol", violation, 1);
    @(negedge clk);
    chk("R4 viol one cycle", violation, 0);
    memData = 8'h77; tbl(1'b0);
    chk("R4 lvl1 internal data", tblData, 8'h77);
    chk("R4 internal no viol", violation, 0);
  endtask

  task automatic t_progByte_R5();
    doReset(2'b11, 1'b1);
    op(3'd0, 8'h12, 1'b0);
    chk("R5 lvl0 grant", progGrant, 1);
    chk("R5 lvl0 write", cellWrEn, 1);
    @(negedge clk);
    chk("R5 write one cycle", cellWrEn, 0);
    doReset(2'b10, 1'b1);
    op(3'd0, 8'h12, 1'b0);
    chk("R5 lvl1 deny", progDeny, 1);
    chk("R5 lvl1 no write", cellWrEn, 0);
  endtask

  task automatic t_readByte_R6();
    doReset(2'b11, 1'b1);
    memData = 8'h81; op(3'd1, 8'h00, 1'b0);
    chk("R6 lvl0 mode1 data", rdData, 8'h81);
    doReset(2'b10, 1'b1);
    memData = 8'h42; op(3'd1, 8'h00, 1'b1);
    chk("R6 lvl1 mode2 data", rdData, 8'h42);
    chk("R6 lvl1 mode2 grant", progGrant, 1);
    op(3'd1, 8'h00, 1'b0);
    chk("R6 lvl1 mode1 blank", rdData, 8'hFF);
    chk("R6 lvl1 mode1 viol", violation, 1);
    chk("R6 lvl1 mode1 deny", progDeny, 1);
    doReset(2'b01, 1'b1);
    memData = 8'h42; op(3'd1, 8'h00, 1'b1);
    chk("R6 lvl2 mode2 blank", rdData, 8'hFF);
    chk("R6 lvl2 viol", violation, 1);
  endtask

  task automatic t_level3_R7();
    doReset(2'b01, 1'b0);
    @(negedge clk);
    chk("R7 lvl2 pin low allowed", extExec, 1);
    doReset(2'b00, 1'b0);
    extPin = 0; @(negedge clk);
    chk("R7 lvl3 pin low refused", extExec, 0);
    jumpAbove = 1; @(negedge clk);
    chk("R7 lvl3 jump allowed", extExec, 1);
    jumpAbove = 0; @(negedge clk);
    chk("R7 lvl3 jump gone", extExec, 0);
    extPin = 1;
  endtask

  task automatic t_lockRead_R8();
    doReset(2'b00, 1'b1);
    op(3'd3, 8'h00, 1'b0);
    chk("R8 lvl3 lock read", rdData, 8'h00);
    chk("R8 lvl3 lock grant", progGrant, 1);
    op(3'd4, 8'h00, 1'b0);
    chk("R8 lvl3 version", rdData, VER);
    doReset(2'b10, 1'b1);
    op(3'd3, 8'h00, 1'b0);
    chk("R8 lvl1 lock read", rdData, 8'h02);
  endtask

  task automatic t_lockProg_R9();
    doReset(2'b11, 1'b1);
    op(3'd2, 8'h02, 1'b0);
    chk("R9 lock prog grant", progGrant, 1);
    chk("R9 level not yet", level, 0);
    @(negedge clk);
    chk("R9 level risen", level, 1);
    op(3'd2, 8'h03, 1'b0);
    @(negedge clk);
    op(3'd3, 8'h00, 1'b0);
    chk("R9 no bit restored", rdData, 8'h02);
    chk("R9 level held", level, 1);
    op(3'd2, 8'h01, 1'b0);
    @(negedge clk);
    chk("R9 level top", level, 3);
    op(3'd3, 8'h00, 1'b0);
    chk("R9 lock cleared", rdData, 8'h00);
  endtask

  task automatic t_badOp_R10();
    doReset(2'b11, 1'b1);
    op(3'd4, 8'h00, 1'b0);
    for (int c = 5; c < 8; c++) begin
      op(3'(c), 8'h00, 1'b0);
      chk("R10 bad op deny", progDeny, 1);
      chk("R10 bad op no grant", progGrant, 0);
      chk("R10 rdData kept", rdData, VER);
    end
  endtask

  initial begin
    rstN = 0; lockInit = 2'b11; extPin = 1; memData = 0; idle();
    t_decode_R1();
    t_livePin_R2();
    t_latch_R3();
    t_table_R4();
    t_progByte_R5();
    t_readByte_R6();
    t_level3_R7();
    t_lockRead_R8();
    t_lockProg_R9();
    t_badOp_R10();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule